// File: doc/BRIEF.md
# Relocatable Legacy I/O Function Decoder

This block sits on a legacy I/O bus and decides which of four on-chip legacy functions answers a given port address. The four functions are a floppy controller, a parallel port and two serial ports. Each function has an enable and a base address held in a small byte-wide configuration file. The surrounding device logic uses the four select outputs as chip-selects.

Software reaches the configuration file through a pair of ports: an index port that picks a register and a data port that reads or writes it. Both ports are live only while the configuration-access enable input is high. Each base address is packed into one byte and expanded by a per-function mask and a left shift of two. A write to any configuration register moves or gates the decode windows from the next clock onward. Reset leaves the two serial ports enabled at their usual addresses, while the floppy and parallel functions stay off.

Top module: `sio_func_decoder`

## Requirements
- R1: After reset the registers read back as follows: index 0xE0 = 0x3C, 0xE2 = 0x0F, 0xE3 = 0xFC, 0xE6 = 0xDE, 0xE7 = 0xFE, 0xE8 = 0xBE. The index register resets to 0x00. Only serial 1 (0x3F8–0x3FF) and serial 2 (0x2F8–0x2FF) select.
- R2: While `cfg_en` is high, a write to port 0x3F0 loads the index, and a write to port 0x3F1 writes the indexed register. A read of 0x3F1 returns the indexed register, and a read of 0x3F0 returns the index. `io_rdata` is 0x00 whenever no such read is in progress.
- R3: In register 0xE2, the parallel port is disabled only when bits [1:0] equal 2'b11. The codes 0, 1 and 2 all enable it.
- R4: In register 0xE2, bit 2 enables serial 1, bit 3 enables serial 2 and bit 4 enables the floppy controller.
- R5: The floppy base is (reg 0xE3 & 0xFC) << 2. The register itself reads back the full byte that was written.
- R6: The parallel base is (reg 0xE6) << 2. A window matches when (addr & ~7) equals the base, so a base with bit 2 set never selects.
- R7: The serial 1 base is (reg 0xE7 & 0xFE) << 2, and the serial 2 base is (reg 0xE8 & 0xFE) << 2. Each window is 8 ports wide.
- R8: Index 0xE0 and indices 0xFD–0xFF are read-only. Writes to them, and to any unimplemented index, have no effect. Unimplemented indices and 0xFD–0xFF read as 0x00.
- R9: A configuration write changes the select outputs in the cycle after its clock edge. With no such write and a steady address, the selects hold.
- R10: While `cfg_en` is low, accesses to 0x3F0/0x3F1 do not touch the configuration file and are decoded like any other address. While `cfg_en` is high, no select asserts at those two addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables the index/data configuration ports |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data from the configuration ports |
| sel_fdc | output | 1 | Floppy controller select |
| sel_lpt | output | 1 | Parallel port select |
| sel_ser1 | output | 1 | Serial port 1 select |
| sel_ser2 | output | 1 | Serial port 2 select |

## Verification
Some checks are made on every cycle. No select asserts on a configuration port while access is enabled. The index port echoes a shadow copy of the index. The read-only identity byte and the 0xFD–0xFF locations read back fixed values. The selects stay steady unless the address, the access enable or a configuration write changes. The bench scenarios show the rest: the exact window arithmetic for each mask and shift, the three enabling codes of the parallel field, the unreachable parallel base, the index and data writes being ignored while access is off, and the return to the non-zero reset values after a mid-run reset.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_FN = 4;

  typedef enum int {
    FN_FDC  = 0,
    FN_LPT  = 1,
    FN_SER1 = 2,
    FN_SER2 = 3
  } fn_id_e;

  localparam logic [BYTE_W-1:0] IDX_DEVID = 8'hE0;
  localparam logic [BYTE_W-1:0] IDX_FSEL  = 8'hE2;
  localparam logic [BYTE_W-1:0] IDX_FDC   = 8'hE3;
  localparam logic [BYTE_W-1:0] IDX_LPT   = 8'hE6;
  localparam logic [BYTE_W-1:0] IDX_SER1  = 8'hE7;
  localparam logic [BYTE_W-1:0] IDX_SER2  = 8'hE8;

  localparam logic [BYTE_W-1:0] RST_DEVID = 8'h3C;
  localparam logic [BYTE_W-1:0] RST_FSEL  = 8'h0F;
  localparam logic [BYTE_W-1:0] RST_FDC   = 8'hFC;
  localparam logic [BYTE_W-1:0] RST_LPT   = 8'hDE;
  localparam logic [BYTE_W-1:0] RST_SER1  = 8'hFE;
  localparam logic [BYTE_W-1:0] RST_SER2  = 8'hBE;

  // Mask applied to each packed base byte before the shift by two.
  function automatic logic [BYTE_W-1:0] fn_mask(input int fn);
    case (fn)
      FN_FDC:  fn_mask = 8'hFC;
      FN_LPT:  fn_mask = 8'hFF;
      default: fn_mask = 8'hFE;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h3F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h3F1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_en,
  input  logic [ADDR_W-1:0]             io_addr,
  input  logic                          io_wr,
  input  logic                          io_rd,
  input  logic [BYTE_W-1:0]             io_wdata,
  output logic [BYTE_W-1:0]             io_rdata,
  output logic [BYTE_W-1:0]             fsel_q,
  output logic [NUM_FN-1:0][BYTE_W-1:0] fn_reg_q,
  output logic                          cfg_port_hit
);
  logic                          at_index;
  logic                          at_data;
  logic                          idx_we;
  logic                          data_we;
  logic [BYTE_W-1:0]             idx_q;
  logic [BYTE_W-1:0]             idx_d;
  logic [BYTE_W-1:0]             fsel_d;
  logic [NUM_FN-1:0][BYTE_W-1:0] fn_reg_d;
  logic [BYTE_W-1:0]             rd_val;

  assign at_index     = cfg_en && (io_addr == INDEX_PORT);
  assign at_data      = cfg_en && (io_addr == DATA_PORT);
  assign idx_we       = io_wr && at_index;
  assign data_we      = io_wr && at_data;
  assign cfg_port_hit = at_index || at_data;

  // Next-state: only the writable locations take data; others drop it.
  always_comb begin
    idx_d    = io_wdata;
    fsel_d   = fsel_q;
    fn_reg_d = fn_reg_q;
    case (idx_q)
      IDX_FSEL: fsel_d            = io_wdata;
      IDX_FDC:  fn_reg_d[FN_FDC]  = io_wdata;
      IDX_LPT:  fn_reg_d[FN_LPT]  = io_wdata;
      IDX_SER1: fn_reg_d[FN_SER1] = io_wdata;
      IDX_SER2: fn_reg_d[FN_SER2] = io_wdata;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q             <= '0;
      fsel_q            <= RST_FSEL;
      fn_reg_q[FN_FDC]  <= RST_FDC;
      fn_reg_q[FN_LPT]  <= RST_LPT;
      fn_reg_q[FN_SER1] <= RST_SER1;
      fn_reg_q[FN_SER2] <= RST_SER2;
    end else begin
      if (idx_we) begin
        idx_q <= idx_d;
      end
      if (data_we) begin
        fsel_q   <= fsel_d;
        fn_reg_q <= fn_reg_d;
      end
    end
  end

  // Read mux for the data port.
  always_comb begin
    case (idx_q)
      IDX_DEVID: rd_val = RST_DEVID;
      IDX_FSEL:  rd_val = fsel_q;
      IDX_FDC:   rd_val = fn_reg_q[FN_FDC];
      IDX_LPT:   rd_val = fn_reg_q[FN_LPT];
      IDX_SER1:  rd_val = fn_reg_q[FN_SER1];
      IDX_SER2:  rd_val = fn_reg_q[FN_SER2];
      default:   rd_val = '0;
    endcase
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && at_data) begin
      io_rdata = rd_val;
    end else if (io_rd && at_index) begin
      io_rdata = idx_q;
    end
  end
endmodule

// File: rtl/sio_func_ctrl.sv
module sio_func_ctrl
  import sio_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [BYTE_W-1:0]             fsel_q,
  input  logic [NUM_FN-1:0][BYTE_W-1:0] fn_reg_q,
  output logic [NUM_FN-1:0]             fn_en,
  output logic [NUM_FN-1:0][ADDR_W-1:0] fn_base
);
  localparam int EXP_W = BYTE_W + 2;

  always_comb begin
    fn_en          = '0;
    fn_en[FN_FDC]  = fsel_q[4];
    fn_en[FN_LPT]  = (fsel_q[1:0] != 2'b11);
    fn_en[FN_SER1] = fsel_q[2];
    fn_en[FN_SER2] = fsel_q[3];
  end

  for (genvar g = 0; g < NUM_FN; g++) begin : g_base
    logic [EXP_W-1:0] expanded;
    assign expanded   = {fn_reg_q[g] & fn_mask(g), 2'b00};
    assign fn_base[g] = ADDR_W'(expanded);
  end
endmodule

// File: rtl/sio_win_match.sv
module sio_win_match #(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 3
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  input  logic              block,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << WIN_LOG2) - 1);

  assign hit = en && !block && ((io_addr & ~LOW_MASK) == base);
endmodule

// File: rtl/sio_func_decoder.sv
module sio_func_decoder
  import sio_dec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 3,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h3F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h3F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              sel_fdc,
  output logic              sel_lpt,
  output logic              sel_ser1,
  output logic              sel_ser2
);
  logic [BYTE_W-1:0]             fsel_q;
  logic [NUM_FN-1:0][BYTE_W-1:0] fn_reg_q;
  logic                          cfg_port_hit;
  logic [NUM_FN-1:0]             fn_en;
  logic [NUM_FN-1:0][ADDR_W-1:0] fn_base;
  logic [NUM_FN-1:0]             sel_vec;

  sio_cfg_regs #(
    .ADDR_W     (ADDR_W),
    .INDEX_PORT (INDEX_PORT),
    .DATA_PORT  (DATA_PORT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .fsel_q       (fsel_q),
    .fn_reg_q     (fn_reg_q),
    .cfg_port_hit (cfg_port_hit)
  );

  sio_func_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .fsel_q   (fsel_q),
    .fn_reg_q (fn_reg_q),
    .fn_en    (fn_en),
    .fn_base  (fn_base)
  );

  for (genvar g = 0; g < NUM_FN; g++) begin : g_win
    sio_win_match #(
      .ADDR_W   (ADDR_W),
      .WIN_LOG2 (WIN_LOG2)
    ) u_match (
      .io_addr (io_addr),
      .base    (fn_base[g]),
      .en      (fn_en[g]),
      .block   (cfg_port_hit),
      .hit     (sel_vec[g])
    );
  end

  assign sel_fdc  = sel_vec[FN_FDC];
  assign sel_lpt  = sel_vec[FN_LPT];
  assign sel_ser1 = sel_vec[FN_SER1];
  assign sel_ser2 = sel_vec[FN_SER2];
endmodule

// File: rtl/sio_func_decoder_chk.sv
module sio_func_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h3F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h3F1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              sel_fdc,
  input logic              sel_lpt,
  input logic              sel_ser1,
  input logic              sel_ser2
);
  logic [7:0] sh_idx;
  logic       on_cfg;
  logic       data_wr;
  logic [3:0] sels;

  assign on_cfg  = cfg_en && (io_addr == INDEX_PORT || io_addr == DATA_PORT);
  assign data_wr = io_wr && cfg_en && (io_addr == DATA_PORT);
  assign sels    = {sel_ser2, sel_ser1, sel_lpt, sel_fdc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_idx <= '0;
    end else if (io_wr && cfg_en && io_addr == INDEX_PORT) begin
      sh_idx <= io_wdata;
    end
  end

  assert_cfg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    on_cfg |-> (sels == 4'b0000));

  assert_index_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_en && io_addr == INDEX_PORT) |-> (io_rdata == sh_idx));

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

  assert_devid_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_en && io_addr == DATA_PORT && sh_idx == 8'hE0) |-> (io_rdata == 8'h3C));

  assert_ro_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_en && io_addr == DATA_PORT && sh_idx >= 8'hFD) |-> (io_rdata == 8'h00));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(io_addr) && $stable(cfg_en) && !$past(data_wr)) |-> $stable(sels));
endmodule

bind sio_func_decoder sio_func_decoder_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_PORT (INDEX_PORT),
  .DATA_PORT  (DATA_PORT)
) u_chk (.*);

// File: tb/sio_func_decoder_bench.sv
module sio_func_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NV         = 79;
  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_R = 2'd1;
  localparam logic [1:0] OP_S = 2'd2;

  // {req[3:0], op[1:0], cfg, addr[15:0], val[7:0]}
  function automatic logic [30:0] mk(input int req, input logic [1:0] op,
                                     input logic c, input int a, input int v);
    mk = {4'(req), op, c, 16'(a), 8'(v)};
  endfunction

  localparam logic [30:0] VEC [NV] = '{
    // R1 reset readback
    mk(1, OP_W, 1, 'h3F0, 'hE0), mk(1, OP_R, 1, 'h3F1, 'h3C),
    mk(1, OP_W, 1, 'h3F0, 'hE2), mk(1, OP_R, 1, 'h3F1, 'h0F),
    mk(1, OP_W, 1, 'h3F0, 'hE3), mk(1, OP_R, 1, 'h3F1, 'hFC),
    mk(1, OP_W, 1, 'h3F0, 'hE6), mk(1, OP_R, 1, 'h3F1, 'hDE),
    mk(1, OP_W, 1, 'h3F0, 'hE7), mk(1, OP_R, 1, 'h3F1, 'hFE),
    mk(1, OP_W, 1, 'h3F0, 'hE8), mk(1, OP_R, 1, 'h3F1, 'hBE),
    mk(1, OP_S, 0, 'h3F8, 'h4),  mk(1, OP_S, 0, 'h2FD, 'h8),
    mk(1, OP_S, 0, 'h378, 'h0),  mk(1, OP_S, 0, 'h3F0, 'h0),
    // R2 index echo
    mk(2, OP_R, 1, 'h3F0, 'hE8),
    // R4 / R3 function select
    mk(4, OP_W, 1, 'h3F0, 'hE2), mk(4, OP_W, 1, 'h3F1, 'h10),
    mk(4, OP_S, 0, 'h3F3, 'h1),  mk(3, OP_S, 0, 'h378, 'h2),
    mk(4, OP_S, 0, 'h3F8, 'h0),  mk(4, OP_S, 0, 'h2F8, 'h0),
    mk(3, OP_W, 1, 'h3F1, 'h1E), mk(3, OP_S, 0, 'h37F, 'h2),
    mk(4, OP_S, 0, 'h3F9, 'h4),  mk(4, OP_S, 0, 'h2FA, 'h8),
    mk(3, OP_W, 1, 'h3F1, 'h1D), mk(3, OP_S, 0, 'h37C, 'h2),
    mk(3, OP_W, 1, 'h3F1, 'h1F), mk(3, OP_S, 0, 'h378, 'h0),
    // R10 config port suppression
    mk(10, OP_S, 0, 'h3F1, 'h1), mk(10, OP_S, 1, 'h3F1, 'h0),
    mk(10, OP_S, 1, 'h3F2, 'h1),
    // R5 floppy relocation
    mk(5, OP_W, 1, 'h3F0, 'hE3), mk(5, OP_W, 1, 'h3F1, 'hBF),
    mk(5, OP_S, 0, 'h2F5, 'h1),  mk(5, OP_S, 0, 'h2EF, 'h0),
    mk(5, OP_S, 0, 'h3F2, 'h0),  mk(5, OP_R, 1, 'h3F1, 'hBF),
    // R6 parallel relocation
    mk(6, OP_W, 1, 'h3F0, 'hE6), mk(6, OP_W, 1, 'h3F1, 'h9E),
    mk(6, OP_W, 1, 'h3F0, 'hE2), mk(6, OP_W, 1, 'h3F1, 'h1C),
    mk(6, OP_S, 0, 'h27B, 'h2),  mk(6, OP_S, 0, 'h280, 'h0),
    mk(6, OP_W, 1, 'h3F0, 'hE6), mk(6, OP_W, 1, 'h3F1, 'h9F),
    mk(6, OP_S, 0, 'h278, 'h0),  mk(6, OP_S, 0, 'h27C, 'h0),
    // R7 serial relocation
    mk(7, OP_W, 1, 'h3F0, 'hE7), mk(7, OP_W, 1, 'h3F1, 'h7B),
    mk(7, OP_S, 0, 'h1EC, 'h4),  mk(7, OP_S, 0, 'h1E7, 'h0),
    mk(7, OP_W, 1, 'h3F0, 'hE8), mk(7, OP_W, 1, 'h3F1, 'h5F),
    mk(7, OP_S, 0, 'h17F, 'h8),  mk(7, OP_S, 0, 'h180, 'h0),
    // R8 read-only and unimplemented
    mk(8, OP_W, 1, 'h3F0, 'hE0), mk(8, OP_W, 1, 'h3F1, 'h55),
    mk(8, OP_R, 1, 'h3F1, 'h3C),
    mk(8, OP_W, 1, 'h3F0, 'hFD), mk(8, OP_W, 1, 'h3F1, 'h12),
    mk(8, OP_R, 1, 'h3F1, 'h00),
    mk(8, OP_W, 1, 'h3F0, 'hFF), mk(8, OP_W, 1, 'h3F1, 'hA5),
    mk(8, OP_R, 1, 'h3F1, 'h00),
    mk(8, OP_W, 1, 'h3F0, 'hE4), mk(8, OP_W, 1, 'h3F1, 'h77),
    mk(8, OP_R, 1, 'h3F1, 'h00), mk(8, OP_S, 0, 'h1EC, 'h4),
    // R10 access gating
    mk(10, OP_W, 1, 'h3F0, 'hE7), mk(10, OP_W, 0, 'h3F1, 'h00),
    mk(10, OP_W, 0, 'h3F0, 'hE2), mk(10, OP_R, 1, 'h3F1, 'h7B),
    mk(10, OP_S, 0, 'h1EC, 'h4),
    // R9 immediate effect
    mk(9, OP_W, 1, 'h3F1, 'hFE), mk(9, OP_S, 0, 'h3F8, 'h4),
    mk(9, OP_S, 0, 'h1E8, 'h0)
  };

  logic              clk;
  logic              rst_n;
  logic              cfg_en;
  logic [ADDR_W-1:0] io_addr;
  logic              io_wr;
  logic              io_rd;
  logic [7:0]        io_wdata;
  logic [7:0]        io_rdata;
  logic              sel_fdc;
  logic              sel_lpt;
  logic              sel_ser1;
  logic              sel_ser2;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  sio_func_decoder u_sio_func_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .sel_fdc  (sel_fdc),
    .sel_lpt  (sel_lpt),
    .sel_ser1 (sel_ser1),
    .sel_ser2 (sel_ser2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input int req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic c, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b0; cfg_en = c; io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input int req, input logic c, input logic [ADDR_W-1:0] a,
                         input logic [7:0] exp);
    @(negedge clk);
    io_wr = 1'b0; cfg_en = c; io_addr = a; io_rd = 1'b1;
    #2;
    check(req, int'(io_rdata), int'(exp), "read data");
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_sel(input int req, input logic c, input logic [ADDR_W-1:0] a,
                        input logic [3:0] exp);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; cfg_en = c; io_addr = a;
    #2;
    check(req, int'({sel_ser2, sel_ser1, sel_lpt, sel_fdc}), int'(exp), "selects");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R0 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle read data and reset index
    #2;
    check(1, int'(io_rdata), 0, "idle read data after reset");
    do_read(1, 1'b1, 16'h03F0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      case (v[26:25])
        OP_W:    do_write(v[24], v[23:8], v[7:0]);
        OP_R:    do_read(int'(v[30:27]), v[24], v[23:8], v[7:0]);
        default: do_sel(int'(v[30:27]), v[24], v[23:8], v[3:0]);
      endcase
    end

    // R1: mid-run reset restores the non-zero defaults
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(1, int'({sel_ser2, sel_ser1, sel_lpt, sel_fdc}), 0, "selects at 0x1E8 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    do_read(1, 1'b1, 16'h03F0, 8'h00);
    do_write(1'b1, 16'h03F0, 8'hE2);
    do_read(1, 1'b1, 16'h03F1, 8'h0F);
    do_sel(1, 1'b0, 16'h03F8, 4'h4);
    do_sel(1, 1'b0, 16'h02F8, 4'h8);
    do_sel(1, 1'b0, 16'h01E8, 4'h0);
    do_sel(1, 1'b0, 16'h02F0, 4'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule